// File: doc/BRIEF.md
# Vector Compare to Predicate Mask

This block executes a compare whose two operands may each be a scalar register or a vector spread across consecutive registers of the integer register file. It does not branch on the outcome. It steps through the elements one per cycle and collects each element's compare result into one bit of a mask word. That word is then written to a chosen integer register, where later predicated instructions can use it.

An operand whose assigned length is above one is a vector and advances one register per element. Any other operand is a scalar: its base register is broadcast against every element. When both operands are scalar, no mask is built. The block instead reports the compare outcome as an ordinary conditional branch decision, and the branch logic outside the block acts on it.

The block reads the register file through two combinational read lanes, one for each operand. It writes the mask through a single write port.

Top module: `vcmp_mask`

## Requirements
- R1: An operand whose length input is greater than 1 is a vector. Otherwise it is a scalar, and a scalar operand presents its base register address for every element.
- R2: For element i, a vector operand reads register (base + i) modulo NREG.
- R3: Compare codes are 0 equal, 1 not-equal, 4 signed less-than, 5 signed greater-or-equal, 6 unsigned less-than and 7 unsigned greater-or-equal. Codes 2 and 3 give false for every element.
- R4: Bit i of the written mask holds the compare result of element i. Every bit at index vl or above is 0.
- R5: When both operands are scalar, no mask is written. `br_valid` pulses for one cycle, and `br_taken` gives the compare of the two base registers. This pulse appears 2 cycles after the start cycle.
- R6: One element is evaluated per cycle. `done` and `wr_en` pulse together for one cycle, vl+1 cycles after the cycle in which start is sampled, and `wr_addr` carries the target register.
- R7: A vl of 0 writes a mask of 0 one cycle after start. A vl above XLEN is treated as XLEN.
- R8: A start that arrives while `busy` is high is ignored.
- R9: After reset, `busy`, `done`, `wr_en` and `br_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| a_base | input | AW | First operand base register |
| a_len | input | LW | First operand assigned length |
| b_base | input | AW | Second operand base register |
| b_len | input | LW | Second operand assigned length |
| vl | input | LW | Vector length |
| cmp_op | input | 3 | Compare code |
| dst_reg | input | AW | Register receiving the mask |
| rd_addr_a | output | AW | Read address, first operand |
| rd_data_a | input | XLEN | Read data, first operand |
| rd_addr_b | output | AW | Read address, second operand |
| rd_data_b | input | XLEN | Read data, second operand |
| busy | output | 1 | Operation in progress |
| wr_en | output | 1 | Mask write strobe |
| wr_addr | output | AW | Mask write register |
| wr_data | output | XLEN | Mask word |
| done | output | 1 | Mask written this cycle |
| br_valid | output | 1 | Scalar-scalar branch decision valid |
| br_taken | output | 1 | Branch condition outcome |

## Verification
The compare runs with several operand shapes:

- Vector against vector shows that both address lanes advance together.
- Scalar against vector and vector against scalar show that the broadcast comes from the correct side.
- A register file that mixes negative, positive and repeated values tells the signed, unsigned and equality codes apart.

The boundary cases are a vl of zero, a vl above XLEN, a unit vl, a vector that wraps past the last register, and the scalar-scalar branch fallback. A start that arrives mid-operation confirms that it leaves the result and the pulse count unchanged.

// File: rtl/vcmp_mask.sv
module vcmp_mask #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW = $clog2(NREG),
  localparam int LW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   a_base,
  input  logic [LW-1:0]   a_len,
  input  logic [AW-1:0]   b_base,
  input  logic [LW-1:0]   b_len,
  input  logic [LW-1:0]   vl,
  input  logic [2:0]      cmp_op,
  input  logic [AW-1:0]   dst_reg,
  output logic [AW-1:0]   rd_addr_a,
  input  logic [XLEN-1:0] rd_data_a,
  output logic [AW-1:0]   rd_addr_b,
  input  logic [XLEN-1:0] rd_data_b,
  output logic            busy,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [XLEN-1:0] wr_data,
  output logic            done,
  output logic            br_valid,
  output logic            br_taken
);

  typedef enum logic [1:0] {IDLE, RUN, FIN, BRN} state_t;

  state_t          state;
  logic [LW-1:0]   idx, vl_q;
  logic [XLEN-1:0] acc;
  logic [AW-1:0]   a_base_q, b_base_q, dst_q;
  logic            a_vec_q, b_vec_q;
  logic [2:0]      op_q;
  logic            res, last, both_scalar;
  logic [LW-1:0]   vl_eff;

  assign vl_eff      = (vl > LW'(XLEN)) ? LW'(XLEN) : vl;
  assign both_scalar = !a_vec_q && !b_vec_q;
  assign last        = both_scalar || (idx == vl_q - 1'b1);

  assign rd_addr_a = a_base_q + (a_vec_q ? AW'(idx) : '0);
  assign rd_addr_b = b_base_q + (b_vec_q ? AW'(idx) : '0);

  always_comb begin
    case (op_q)
      3'd0:    res = rd_data_a == rd_data_b;
      3'd1:    res = rd_data_a != rd_data_b;
      3'd4:    res = $signed(rd_data_a) <  $signed(rd_data_b);
      3'd5:    res = $signed(rd_data_a) >= $signed(rd_data_b);
      3'd6:    res = rd_data_a <  rd_data_b;
      3'd7:    res = rd_data_a >= rd_data_b;
      default: res = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      idx      <= '0;
      vl_q     <= '0;
      acc      <= '0;
      a_base_q <= '0;
      b_base_q <= '0;
      dst_q    <= '0;
      a_vec_q  <= 1'b0;
      b_vec_q  <= 1'b0;
      op_q     <= '0;
    end else begin
      case (state)
        IDLE: if (start) begin
          a_base_q <= a_base;
          b_base_q <= b_base;
          a_vec_q  <= a_len > LW'(1);
          b_vec_q  <= b_len > LW'(1);
          vl_q     <= vl_eff;
          op_q     <= cmp_op;
          dst_q    <= dst_reg;
          idx      <= '0;
          acc      <= '0;
          if (a_len <= LW'(1) && b_len <= LW'(1)) state <= RUN;
          else if (vl_eff == '0)                  state <= FIN;
          else                                    state <= RUN;
        end
        RUN: begin
          acc <= acc | (XLEN'(res) << idx);
          idx <= idx + 1'b1;
          if (last) state <= both_scalar ? BRN : FIN;
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy     = state != IDLE;
  assign done     = state == FIN;
  assign wr_en    = done;
  assign wr_addr  = dst_q;
  assign wr_data  = acc;
  assign br_valid = state == BRN;
  assign br_taken = acc[0];

  logic [XLEN:0] vl_span;
  assign vl_span = ({{XLEN{1'b0}}, 1'b1} << vl_q) - 1'b1;

  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN && !both_scalar) |-> (idx < vl_q));

  p_high_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((wr_data & ~vl_span[XLEN-1:0]) == '0));

  p_branch_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, br_valid}));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(a_base_q) && $stable(dst_q) && $stable(op_q)));

endmodule

// File: tb/vcmp_mask_tb.sv
module vcmp_mask_tb;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int AW = $clog2(NREG);
  localparam int LW = $clog2(XLEN + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] a_base = 0, b_base = 0, dst_reg = 0;
  logic [LW-1:0] a_len = 0, b_len = 0, vl = 0;
  logic [2:0] cmp_op = 0;
  logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
  logic [XLEN-1:0] rd_data_a, rd_data_b, wr_data;
  logic busy, wr_en, done, br_valid, br_taken;
  logic [XLEN-1:0] rf [NREG];
  int total = 0, bad = 0, cycles = 0;

  always #10 clk = ~clk;

  assign rd_data_a = rf[rd_addr_a];
  assign rd_data_b = rf[rd_addr_b];

  vcmp_mask #(.XLEN(XLEN), .NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_base(a_base), .a_len(a_len), .b_base(b_base), .b_len(b_len),
    .vl(vl), .cmp_op(cmp_op), .dst_reg(dst_reg),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .br_valid(br_valid), .br_taken(br_taken));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic cmpf(input logic [2:0] op, input logic [XLEN-1:0] x, input logic [XLEN-1:0] y);
    case (op)
      3'd0: return x == y;
      3'd1: return x != y;
      3'd4: return $signed(x) < $signed(y);
      3'd5: return $signed(x) >= $signed(y);
      3'd6: return x < y;
      3'd7: return x >= y;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] model(input int ab, input int al, input int bb, input int bl, input int n, input logic [2:0] op);
    logic [XLEN-1:0] m = '0;
    int nn = (n > XLEN) ? XLEN : n;
    for (int i = 0; i < nn; i++) begin
      logic [XLEN-1:0] x = rf[(al > 1) ? (ab + i) % NREG : ab];
      logic [XLEN-1:0] y = rf[(bl > 1) ? (bb + i) % NREG : bb];
      m[i] = cmpf(op, x, y);
    end
    return m;
  endfunction

  task automatic run_vec(input string req, input int ab, input int al, input int bb, input int bl,
                         input int n, input logic [2:0] op, input int dst);
    int cyc = 0;
    int ne = (n > XLEN) ? XLEN : n;
    logic [XLEN-1:0] exp = model(ab, al, bb, bl, n, op);
    @(negedge clk);
    a_base = AW'(ab); a_len = LW'(al); b_base = AW'(bb); b_len = LW'(bl);
    vl = LW'(n); cmp_op = op; dst_reg = AW'(dst); start = 1;
    while (cyc < 200) begin
      @(negedge clk); cyc++; start = 0;
      if (done || br_valid) break;
    end
    check({req, " done"}, {31'd0, done}, 1);
    check({req, " R6 latency"}, cyc, ne + 1);
    check({req, " R4 mask"}, wr_data, exp);
    check({req, " R6 wr_addr"}, {27'd0, wr_addr}, dst);
    check({req, " R6 wr_en"}, {31'd0, wr_en}, 1);
    @(negedge clk);
    check({req, " R6 pulse"}, {31'd0, done}, 0);
  endtask

  task automatic t_reset;
    check("R9 busy", {31'd0, busy}, 0);
    check("R9 done", {31'd0, done}, 0);
    check("R9 wr_en", {31'd0, wr_en}, 0);
    check("R9 br_valid", {31'd0, br_valid}, 0);
  endtask

  task automatic t_scalar_branch(input int ab, input int bb, input logic [2:0] op);
    int cyc = 0;
    logic sawwr = 0;
    @(negedge clk);
    a_base = AW'(ab); a_len = 1; b_base = AW'(bb); b_len = 0;
    vl = 8; cmp_op = op; dst_reg = 9; start = 1;
    while (cyc < 200) begin
      @(negedge clk); cyc++; start = 0;
      if (wr_en) sawwr = 1;
      if (br_valid || done) break;
    end
    check("R5 br_valid", {31'd0, br_valid}, 1);
    check("R5 latency", cyc, 2);
    check("R5 br_taken", {31'd0, br_taken}, {31'd0, cmpf(op, rf[ab], rf[bb])});
    check("R5 no write", {31'd0, wr_en | sawwr}, 0);
    @(negedge clk);
    check("R5 pulse", {31'd0, br_valid}, 0);
  endtask

  task automatic t_busy_start;
    int cyc = 0, ndone = 0;
    logic [XLEN-1:0] exp = model(0, 4, 8, 4, 6, 3'd6);
    logic [XLEN-1:0] got = '0;
    @(negedge clk);
    a_base = 0; a_len = 4; b_base = 8; b_len = 4; vl = 6; cmp_op = 6; dst_reg = 3; start = 1;
    @(negedge clk);
    a_base = 20; b_base = 2; vl = 30; cmp_op = 0; dst_reg = 7; start = 1;
    @(negedge clk); start = 0;
    while (cyc < 60) begin
      @(negedge clk); cyc++;
      if (done) begin ndone++; got = wr_data; check("R8 addr", {27'd0, wr_addr}, 3); end
    end
    check("R8 mask", got, exp);
    check("R8 single done", ndone, 1);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++)
      rf[i] = (i % 3 == 0) ? 32'd5 : (i * 32'h1357_9BDF) ^ ((i & 1) ? 32'h8000_0000 : 32'h0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    run_vec("R2 vv eq", 0, 8, 9, 8, 8, 3'd0, 4);
    run_vec("R1 sv eq broadcast", 3, 1, 10, 12, 12, 3'd0, 5);
    run_vec("R1 vs ltu", 2, 5, 6, 0, 10, 3'd6, 6);
    run_vec("R3 ne", 1, 4, 1, 4, 4, 3'd1, 7);
    run_vec("R3 lt signed", 4, 9, 12, 9, 9, 3'd4, 8);
    run_vec("R3 ge signed", 4, 9, 12, 9, 9, 3'd5, 8);
    run_vec("R3 geu", 4, 9, 12, 9, 9, 3'd7, 8);
    run_vec("R3 code2 false", 0, 5, 0, 5, 5, 3'd2, 8);
    run_vec("R2 wrap", 28, 8, 1, 8, 8, 3'd6, 10);
    run_vec("R4 unit vl", 3, 2, 6, 2, 1, 3'd0, 11);
    run_vec("R7 vl zero", 0, 4, 4, 4, 0, 3'd1, 12);
    run_vec("R7 vl clamp", 0, 33, 31, 33, 40, 3'd1, 13);
    t_scalar_branch(3, 6, 3'd0);
    t_scalar_branch(1, 2, 3'd4);
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule